// File: doc/BRIEF.md
# Eight-line programmable interrupt controller

This block collects eight interrupt request lines, holds them in a request register, and reports the most urgent unmasked one to the processor on `int_o`. When the processor acknowledges, the block marks that line as in service and returns an 8-bit vector equal to a programmed base plus the line number. It can instead name, on the cascade output, a slave unit that must supply the vector. Software clears service state with an end-of-interrupt command or lets the block do it automatically.

Software programs the block through a byte-wide port with two addresses. A setup word at the low address starts a sequence of two to four words. Flags in the first word decide which of the later words are expected. After setup, the high address holds the line mask and the low address takes commands. These commands select which register is read back, enter a one-shot poll, switch special mask mode, or end an interrupt. In a pair, the master sends a slave-attached line's number on the cascade output. The slave answers an acknowledge only when that number matches its own identity.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at the high address, and `int_o` stays low until the setup sequence has finished.
- R2: A low-address write with bit 4 set restarts setup and clears the mask. High-address writes then go to the base word, then to the cascade word unless bit 1 of the first word was 1, then to the mode word if bit 0 was 1. Only after that do they load the mask.
- R3: The cycle after an accepted acknowledge, `vec_vld_o` pulses with `vec_o` = base + line number (mod 256).
- R4: A mask bit of 1 keeps its line from raising `int_o`. Clearing the bit lets a still-latched request through. The mask reads back at the high address.
- R5: Line 0 has top priority. A request raises `int_o` only when its line outranks every in-service line.
- R6: Acknowledge sets the chosen in-service bit and clears its edge-latched request.
- R7: A low-address write with bits 4:3 = 00 and bits 7:5 = 001 clears the highest-priority in-service bit.
- R8: With automatic end of interrupt (mode word bit 1), acknowledge leaves no in-service bit set.
- R9: A low-address write with bit 4 = 0 and bit 3 = 1 is a command word. In it, bits 1:0 = 10 make low-address reads return the request register, and 11 make them return the in-service register; 0x leaves the choice as it was. After setup the request register is selected.
- R10: With first-word bit 3 = 0, a rising edge latches a request, and a line already high at setup must fall and rise again. With bit 3 = 1, the request follows the line level.
- R11: In the command word of R9, bits 6:5 = 11 enter special mask mode and 10 leave it. In this mode an in-service line blocks only itself.
- R12: Setting bit 2 in the command word of R9 makes the next low-address read return {pending, 0000, line}. That read services the line as an acknowledge would.
- R13: A master acknowledging a line set in its cascade word pulses `cas_vld_o` with `cas_o` = line and gives no vector. A slave ignores acknowledges whose `cas_i` differs from bits 2:0 of its cascade word.
- R14: An acknowledge with no eligible request returns base + 7 and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus select |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| a0_i | input | 1 | Address bit: 0 low, 1 high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected address |
| irq_i | input | 8 | Request lines, bit n is line n |
| master_i | input | 1 | Cascade role: 1 master, 0 slave |
| cas_i | input | 3 | Slave: identity driven by the master |
| inta_i | input | 1 | Acknowledge pulse, one cycle |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector |
| vec_vld_o | output | 1 | Vector valid pulse |
| cas_o | output | 3 | Master: line number of the serviced slave |
| cas_vld_o | output | 1 | Cascade output valid pulse |

## Verification
Priority is tried with a single line, with two lines raised together around an in-service lower line, and with a lower line waiting behind an in-service higher one. Together these separate correct ranking from simple first-come handling and show that blocking is lifted by end of interrupt. The bench repeats these cases with a mask bit set, in special mask mode, through the poll read and with no request at all. This shows that each path selects from the same eligible set. Setup is repeated in edge and level modes, with and without the cascade word, with a line held high across the restart, and in the slave role. These runs show that the word sequence, the edge reset and the identity match each depend on the flags written earlier.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int DW = 8;
  localparam int NL = DW;
  localparam int LW = $clog2(NL);

  typedef enum logic [2:0] {ST_OFF, ST_W2, ST_W3, ST_W4, ST_RUN} seq_e;

  typedef struct packed {
    logic [DW-1:0] base;
    logic [DW-1:0] casc;
    logic          level;
    logic          single;
    logic          aeoi;
  } cfg_t;
endpackage

// File: rtl/pic8_cfg_seq.sv
module pic8_cfg_seq
  import pic8_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          poll_clr_i,
  output cfg_t          cfg_o,
  output logic          ready_o,
  output logic [DW-1:0] mask_o,
  output logic          rsel_isr_o,
  output logic          poll_o,
  output logic          smm_o,
  output logic          init_o,
  output logic          eoi_o
);
  seq_e st_q;
  cfg_t cfg_q;
  logic ic4_q;

  logic start, hi_wr, run, cmd3, cmd2;
  assign start = wr_i & ~a0_i & wdata_i[4];
  assign hi_wr = wr_i & a0_i;
  assign run   = (st_q == ST_RUN);
  assign cmd3  = run & wr_i & ~a0_i & ~wdata_i[4] & wdata_i[3];
  assign cmd2  = run & wr_i & ~a0_i & (wdata_i[4:3] == 2'b00);

  assign init_o  = start;
  assign eoi_o   = cmd2 & (wdata_i[7:5] == 3'b001);
  assign ready_o = run;
  assign cfg_o   = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_OFF;
      cfg_q      <= '0;
      ic4_q      <= 1'b0;
      mask_o     <= '1;
      rsel_isr_o <= 1'b0;
      poll_o     <= 1'b0;
      smm_o      <= 1'b0;
    end else if (start) begin
      st_q         <= ST_W2;
      cfg_q.level  <= wdata_i[3];
      cfg_q.single <= wdata_i[1];
      cfg_q.aeoi   <= 1'b0;
      ic4_q        <= wdata_i[0];
      mask_o       <= '0;
      rsel_isr_o   <= 1'b0;
      poll_o       <= 1'b0;
      smm_o        <= 1'b0;
    end else begin
      unique case (st_q)
        ST_W2: if (hi_wr) begin
          cfg_q.base <= wdata_i;
          st_q <= !cfg_q.single ? ST_W3 : (ic4_q ? ST_W4 : ST_RUN);
        end
        ST_W3: if (hi_wr) begin
          cfg_q.casc <= wdata_i;
          st_q <= ic4_q ? ST_W4 : ST_RUN;
        end
        ST_W4: if (hi_wr) begin
          cfg_q.aeoi <= wdata_i[1];
          st_q <= ST_RUN;
        end
        ST_RUN: begin
          if (hi_wr) mask_o <= wdata_i;
          if (poll_clr_i) poll_o <= 1'b0;
          if (cmd3) begin
            if (wdata_i[1]) rsel_isr_o <= wdata_i[0];
            if (wdata_i[2]) poll_o <= 1'b1;
            if (wdata_i[6]) smm_o <= wdata_i[5];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic8_req.sv
module pic8_req #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         level_i,
  input  logic [N-1:0] lines_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] line_q, edge_q;

  // line_q forced high on setup so a held line needs a fresh rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '1;
      edge_q <= '0;
    end else if (init_i) begin
      line_q <= '1;
      edge_q <= '0;
    end else begin
      line_q <= lines_i;
      edge_q <= (edge_q | (lines_i & ~line_q)) & ~clr_i;
    end
  end

  assign irr_o = level_i ? line_q : edge_q;
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NL-1:0] irq_i,
  input  logic          master_i,
  input  logic [LW-1:0] cas_i,
  input  logic          inta_i,
  output logic          int_o,
  output logic [DW-1:0] vec_o,
  output logic          vec_vld_o,
  output logic [LW-1:0] cas_o,
  output logic          cas_vld_o
);
  cfg_t          cfg_q;
  logic          ready, rsel_isr, poll_q, smm, init_go, eoi_go, poll_go;
  logic [DW-1:0] mask_q;
  logic [NL-1:0] irr, isr_q, isr_d, allow, cand, clr;
  logic          isr_found, req_found;
  logic [LW-1:0] isr_idx, req_idx;
  logic          respond, ack_go, svc, to_slave;

  assign poll_go = cs_i & rd_i & ~a0_i & poll_q & ready;

  pic8_cfg_seq u_seq (
    .clk_i, .rst_ni,
    .wr_i       (cs_i & wr_i),
    .a0_i,
    .wdata_i,
    .poll_clr_i (poll_go),
    .cfg_o      (cfg_q),
    .ready_o    (ready),
    .mask_o     (mask_q),
    .rsel_isr_o (rsel_isr),
    .poll_o     (poll_q),
    .smm_o      (smm),
    .init_o     (init_go),
    .eoi_o      (eoi_go)
  );

  pic8_req #(.N(NL)) u_req (
    .clk_i, .rst_ni,
    .init_i  (init_go),
    .level_i (cfg_q.level),
    .lines_i (irq_i),
    .clr_i   (clr),
    .irr_o   (irr)
  );

  pic8_prio #(.N(NL), .IW(LW)) u_isr_prio (.vec_i(isr_q), .found_o(isr_found), .idx_o(isr_idx));
  pic8_prio #(.N(NL), .IW(LW)) u_req_prio (.vec_i(cand),  .found_o(req_found), .idx_o(req_idx));

  for (genvar g = 0; g < NL; g++) begin : g_allow
    assign allow[g] = smm ? ~isr_q[g] : (~isr_found || (LW'(g) < isr_idx));
  end

  assign cand     = irr & ~mask_q & allow;
  assign int_o    = ready & req_found;
  assign respond  = master_i | cfg_q.single | (cas_i == cfg_q.casc[LW-1:0]);
  assign ack_go   = inta_i & ready & respond;
  assign svc      = (ack_go | poll_go) & req_found;
  assign to_slave = master_i & ~cfg_q.single & cfg_q.casc[req_idx];
  assign clr      = svc ? (NL'(1) << req_idx) : '0;

  always_comb begin
    isr_d = isr_q;
    if (eoi_go && isr_found) isr_d[isr_idx] = 1'b0;
    if (svc && !cfg_q.aeoi)  isr_d[req_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      isr_q <= '0;
    else if (init_go) isr_q <= '0;
    else              isr_q <= isr_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
      cas_o     <= '0;
      cas_vld_o <= 1'b0;
    end else begin
      vec_vld_o <= 1'b0;
      cas_vld_o <= 1'b0;
      if (ack_go) begin
        if (req_found && to_slave) begin
          cas_vld_o <= 1'b1;
          cas_o     <= req_idx;
        end else begin
          vec_vld_o <= 1'b1;
          vec_o     <= cfg_q.base + (req_found ? DW'(req_idx) : DW'(NL-1));
        end
      end
    end
  end

  always_comb begin
    if (a0_i)          rdata_o = mask_q;
    else if (poll_q)   rdata_o = {req_found, {(DW-1-LW){1'b0}}, req_idx};
    else if (rsel_isr) rdata_o = isr_q;
    else               rdata_o = irr;
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
  import pic8_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          int_o,
  input logic          vec_vld_o,
  input logic          cas_vld_o,
  input logic          inta_i,
  input logic          master_i,
  input logic [LW-1:0] cas_i,
  input logic          ready,
  input logic          svc,
  input logic          init_go,
  input logic          eoi_go,
  input logic [NL-1:0] isr_q,
  input logic [LW-1:0] req_idx,
  input cfg_t          cfg_q
);
  a_r1_quiet_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> !int_o);

  a_r13_one_output_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_vld_o && cas_vld_o));

  a_r6_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc && !cfg_q.aeoi && !init_go |=> isr_q[$past(req_idx)]);

  a_r8_auto_eoi_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.aeoi && !init_go |=> $countones(isr_q) <= $past($countones(isr_q)));

  a_r7_eoi_clears_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_go && (|isr_q) && !svc && !init_go |=> $countones(isr_q) == $past($countones(isr_q)) - 1);

  a_r13_slave_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i && !master_i && !cfg_q.single && (cas_i != cfg_q.casc[LW-1:0])
    |=> !vec_vld_o && !cas_vld_o);
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (.*);

// File: tb/test_pic8_ctrl.sv
`timescale 1ns/1ps
module test_pic8_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs = 0, wr_s = 0, rd_s = 0, a0 = 0, master = 1, inta = 0;
  logic [7:0] wd = 0, irq = 0;
  logic [2:0] cas_in = 0;
  logic [7:0] rdata, vec;
  logic [2:0] cas_out;
  logic       int_w, vec_vld, cas_vld;

  int n_cmp = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pic8_ctrl i_pic8_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr_s), .rd_i(rd_s), .a0_i(a0),
    .wdata_i(wd), .rdata_o(rdata), .irq_i(irq), .master_i(master), .cas_i(cas_in),
    .inta_i(inta), .int_o(int_w), .vec_o(vec), .vec_vld_o(vec_vld),
    .cas_o(cas_out), .cas_vld_o(cas_vld)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr_s = 1; a0 = a; wd = d;
    @(negedge clk); cs = 0; wr_s = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd_s = 1; a0 = a; #1 d = rdata;
    @(negedge clk); cs = 0; rd_s = 0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(tag, {1'b0, d}, {1'b0, exp});
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  task automatic int_chk(input logic exp, input string tag);
    #1 chk(tag, {8'b0, int_w}, {8'b0, exp});
  endtask

  // driver: push expected outcome, then pulse acknowledge
  task automatic ack(input logic [2:0] c, input logic push, input logic is_cas,
                     input logic [7:0] val, input string tag);
    if (push) begin exp_q.push_back({is_cas, val}); tag_q.push_back(tag); end
    @(negedge clk); inta = 1; cas_in = c;
    @(negedge clk); inta = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (vec_vld || cas_vld)) begin
      logic [8:0] got;
      got = cas_vld ? {1'b1, 5'b0, cas_out} : {1'b0, vec};
      if (exp_q.size() == 0) chk("R3 unexpected output", got, 9'h1FF);
      else chk(tag_q.pop_front(), got, exp_q.pop_front());
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    int_chk(0, "R1 reset int");
    rd_chk(1, 8'hFF, "R1 reset mask");
    set_irq(8'h01);
    int_chk(0, "R1 no int before setup");
    set_irq(8'h00);

    // master, edge, cascade word and mode word present
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    rd_chk(1, 8'h00, "R2 mask cleared, setup words not taken as mask");
    rd_chk(0, 8'h00, "R9 default request read");
    set_irq(8'h08);
    int_chk(1, "R10 edge latched");
    rd_chk(0, 8'h08, "R9 request register");
    ack(0, 1, 0, 8'h23, "R3 vector base+3");
    wr(0, 8'h0B);
    rd_chk(0, 8'h08, "R6 in-service set");
    wr(0, 8'h0A);
    rd_chk(0, 8'h00, "R6 edge request cleared");
    int_chk(0, "R10 held line no re-trigger");

    // priority around in-service line 3
    set_irq(8'h2A);
    int_chk(1, "R5 line1 above in-service 3");
    ack(0, 1, 0, 8'h21, "R5 line1 chosen before 5");
    int_chk(0, "R5 line5 blocked");
    wr(0, 8'h20);
    wr(0, 8'h0B);
    rd_chk(0, 8'h08, "R7 eoi clears highest only");
    int_chk(0, "R5 line5 below in-service 3");
    wr(0, 8'h20);
    int_chk(1, "R5 line5 released");
    ack(0, 1, 0, 8'h25, "R3 vector base+5");
    wr(0, 8'h20);
    rd_chk(0, 8'h00, "R7 in-service empty");
    wr(0, 8'h0A);

    // masking
    set_irq(8'h00);
    wr(1, 8'h01);
    set_irq(8'h01);
    int_chk(0, "R4 masked line silent");
    rd_chk(1, 8'h01, "R4 mask readback");
    wr(1, 8'h00);
    int_chk(1, "R4 unmask releases latched request");
    ack(0, 1, 0, 8'h20, "R4 vector line0");
    wr(0, 8'h20);

    // cascade line
    set_irq(8'h00);
    set_irq(8'h04);
    ack(0, 1, 1, 8'h02, "R13 master names slave line");
    wr(0, 8'h20);

    // spurious
    set_irq(8'h00);
    int_chk(0, "R14 nothing pending");
    ack(0, 1, 0, 8'h27, "R14 spurious vector");
    wr(0, 8'h0B);
    rd_chk(0, 8'h00, "R14 no in-service set");
    wr(0, 8'h0A);

    // special mask mode
    set_irq(8'h10);
    ack(0, 1, 0, 8'h24, "R3 vector base+4");
    set_irq(8'h50);
    int_chk(0, "R11 line6 blocked normally");
    wr(0, 8'h68);
    int_chk(1, "R11 special mask lets line6 through");
    wr(0, 8'h48);
    int_chk(0, "R11 leaving special mask blocks again");
    wr(0, 8'h68);
    ack(0, 1, 0, 8'h26, "R11 vector line6");
    wr(0, 8'h0B);
    rd_chk(0, 8'h50, "R11 both in service");
    wr(0, 8'h20); wr(0, 8'h20);
    rd_chk(0, 8'h00, "R7 two eoi empty");
    wr(0, 8'h48); wr(0, 8'h0A);

    // poll
    set_irq(8'h00);
    set_irq(8'h80);
    wr(0, 8'h0C);
    rd_chk(0, 8'h87, "R12 poll word");
    wr(0, 8'h0B);
    rd_chk(0, 8'h80, "R12 poll serviced line");
    int_chk(0, "R12 no further request");
    wr(0, 8'h20); wr(0, 8'h0A);

    // restart: single, edge, auto eoi, with line1 held high
    set_irq(8'h02);
    wr(0, 8'h13); wr(1, 8'h60); wr(1, 8'h03);
    int_chk(0, "R10 held line ignored after setup");
    rd_chk(1, 8'h00, "R2 no cascade word, mode word not mask");
    set_irq(8'h00);
    set_irq(8'h02);
    int_chk(1, "R10 fresh edge");
    ack(0, 1, 0, 8'h61, "R3 new base");
    wr(0, 8'h0B);
    rd_chk(0, 8'h00, "R8 auto eoi leaves none");
    int_chk(0, "R8 no request left");

    // restart: level, single, auto eoi
    wr(0, 8'h1B); wr(1, 8'h40); wr(1, 8'h03);
    int_chk(1, "R10 level follows line");
    ack(0, 1, 0, 8'h41, "R10 level vector");
    wr(0, 8'h0B);
    rd_chk(0, 8'h00, "R8 auto eoi level");
    int_chk(1, "R10 level still asserted");
    set_irq(8'h00);
    int_chk(0, "R10 level dropped");

    // slave role, identity 2
    @(negedge clk); master = 0;
    wr(0, 8'h11);
    set_irq(8'h01);
    int_chk(0, "R1 mid-setup");
    wr(1, 8'h70); wr(1, 8'h02); wr(1, 8'h01);
    int_chk(1, "R2 setup done");
    ack(3, 0, 0, 8'h00, "");
    int_chk(1, "R13 slave ignores other identity");
    ack(2, 1, 0, 8'h70, "R13 slave answers own identity");

    repeat (3) @(negedge clk);
    chk("R3 all expected outputs seen", 9'(exp_q.size()), 9'd0);
    summary();
  end
endmodule